// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one integer by another over several clock cycles. It needs only one subtractor as wide as an operand. A single register twice the operand width holds the partial remainder in its upper half. The quotient bits collect in its lower half, filling the places that the dividend bits leave as they shift up. Each cycle the block tries to subtract the divisor from the upper half. If the divisor fits, the difference is kept and a 1 enters at the bottom. If it does not fit, the upper half keeps its old value and a 0 enters. After the last iteration the upper half is moved back right by one place to give the remainder.

A client pulses `start` while the block is idle, with the operands and a mode select. The mode select picks unsigned operation, or signed operation with quotient truncation toward zero. The block raises `busy` at once. One cycle after the final iteration it drops `busy`, pulses `done` and presents registered results. Those results stay in place until the next completion. A new `start` is accepted in the same cycle that `done` is shown. Signed operation divides the magnitudes and then fixes up the signs. A zero divisor does not raise an exception; it gives a fixed result.

Top module: `restoring_divider`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy`, `done`, `quotient` and `remainder` are all zero.
- R2: `start` sampled high while `busy` is low is accepted, and `busy` reads 1 after that edge. `start` sampled while `busy` is high has no effect: the running operation finishes with the operands captured at acceptance.
- R3: `done` rises exactly W+1 clock edges after the accepting edge. It is high for one cycle only, and `busy` is low in that cycle.
- R4: With `signed_mode` = 0, `quotient` is the floor of dividend/divisor and `remainder` is dividend − quotient·divisor, both as unsigned W-bit values. This includes operands with the top bit set.
- R5: With `signed_mode` = 1, the operands are two's complement. The quotient magnitude is |dividend| / |divisor| rounded down, and the quotient is negative when the two operand signs differ. The remainder has the sign of the dividend (−7/2 gives −3 rem −1; 7/−2 gives −3 rem 1; −7/−2 gives 3 rem −1).
- R6: A divisor of zero gives a `quotient` of all ones and a `remainder` equal to the dividend, in both modes.
- R7: In signed mode, the most negative dividend divided by −1 wraps: the quotient is the most negative value and the remainder is 0.
- R8: `quotient` and `remainder` change only in a cycle where `done` is high. They hold their values while a later operation is running.
- R9: An instance with W = 4 dividing 7 (0111) by 2 (0010) unsigned gives quotient 0011 and remainder 0001, after the same W+1 edge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only while idle |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | W | Dividend, captured on acceptance |
| divisor | input | W | Divisor, captured on acceptance |
| busy | output | 1 | High from acceptance until the result cycle |
| done | output | 1 | One-cycle pulse when new results are shown |
| quotient | output | W | Registered quotient (low word of the result) |
| remainder | output | W | Registered remainder (high word of the result) |

## Verification
Two things can fall in the same cycle. A completion is shown (`done` high, new results registered) in the very cycle that a new `start` is sampled. The bench issues every operation back to back: it launches the next request in the cycle where it sees `done`. Part-way through that new operation it confirms that the outputs still hold the previous results. When the new operation completes, the checks confirm its own latency and values. A second overlap is a `start` that arrives while an iteration is running. It is judged by comparing the final result with the operands first accepted.

// File: rtl/srdiv_pkg.sv
package srdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } srdiv_state_t;
endpackage

// File: rtl/srdiv_sign_prep.sv
module srdiv_sign_prep #(
  parameter int W = 32
) (
  input  logic         signed_mode,
  input  logic [W-1:0] dvd,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] dvd_mag,
  output logic [W-1:0] dvs_mag,
  output logic         neg_quo,
  output logic         neg_rem,
  output logic         dvs_zero
);
  logic dvd_neg;
  logic dvs_neg;

  always_comb begin
    dvd_neg  = signed_mode & dvd[W-1];
    dvs_neg  = signed_mode & dvs[W-1];
    dvd_mag  = dvd_neg ? -dvd : dvd;
    dvs_mag  = dvs_neg ? -dvs : dvs;
    neg_quo  = dvd_neg ^ dvs_neg;
    neg_rem  = dvd_neg;
    dvs_zero = (dvs == '0);
  end
endmodule

// File: rtl/srdiv_restore_step.sv
module srdiv_restore_step #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] rem_in,
  input  logic           spill_in,
  input  logic [W-1:0]   dvs,
  output logic [2*W-1:0] rem_out,
  output logic           spill_out
);
  localparam int TW = 2 * W;

  logic [W:0]   diff;
  logic         fits;
  logic [W-1:0] hi_kept;

  always_comb begin
    // borrow of a (W+1)-bit subtraction; a set spill bit means the
    // true upper value exceeds 2^W and the divisor always fits
    diff      = {1'b0, rem_in[TW-1:W]} - {1'b0, dvs};
    fits      = spill_in | ~diff[W];
    hi_kept   = fits ? diff[W-1:0] : rem_in[TW-1:W];
    rem_out   = {hi_kept[W-2:0], rem_in[W-1:0], fits};
    spill_out = hi_kept[W-1];
  end
endmodule

// File: rtl/srdiv_result_fix.sv
module srdiv_result_fix #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] rem_reg,
  input  logic           spill,
  input  logic           neg_quo,
  input  logic           neg_rem,
  input  logic           dvs_zero,
  output logic [W-1:0]   quo_out,
  output logic [W-1:0]   rem_out
);
  localparam int TW = 2 * W;

  logic [W-1:0] quo_mag;
  logic [W-1:0] rem_mag;

  always_comb begin
    quo_mag = rem_reg[W-1:0];
    // right correction shift of the upper half; spill refills the top
    rem_mag = {spill, rem_reg[TW-1:W+1]};
    if (dvs_zero)     quo_out = '1;
    else if (neg_quo) quo_out = -quo_mag;
    else              quo_out = quo_mag;
    rem_out = neg_rem ? -rem_mag : rem_mag;
  end
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         signed_mode,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  import srdiv_pkg::*;

  localparam int TW = 2 * W;
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  srdiv_state_t   state;
  logic [CW-1:0]  iter;
  logic [TW-1:0]  rem_q;
  logic           spill_q;
  logic [W-1:0]   dvs_q;
  logic           neg_quo_q;
  logic           neg_rem_q;
  logic           zero_q;

  logic [W-1:0]   dvd_mag;
  logic [W-1:0]   dvs_mag;
  logic           neg_quo_c;
  logic           neg_rem_c;
  logic           zero_c;
  logic [TW-1:0]  step_rem;
  logic           step_spill;
  logic [W-1:0]   fix_quo;
  logic [W-1:0]   fix_rem;

  srdiv_sign_prep #(.W(W)) u_prep (
    .signed_mode (signed_mode),
    .dvd         (dividend),
    .dvs         (divisor),
    .dvd_mag     (dvd_mag),
    .dvs_mag     (dvs_mag),
    .neg_quo     (neg_quo_c),
    .neg_rem     (neg_rem_c),
    .dvs_zero    (zero_c)
  );

  srdiv_restore_step #(.W(W)) u_step (
    .rem_in    (rem_q),
    .spill_in  (spill_q),
    .dvs       (dvs_q),
    .rem_out   (step_rem),
    .spill_out (step_spill)
  );

  srdiv_result_fix #(.W(W)) u_fix (
    .rem_reg  (rem_q),
    .spill    (spill_q),
    .neg_quo  (neg_quo_q),
    .neg_rem  (neg_rem_q),
    .dvs_zero (zero_q),
    .quo_out  (fix_quo),
    .rem_out  (fix_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      iter      <= '0;
      rem_q     <= '0;
      spill_q   <= 1'b0;
      dvs_q     <= '0;
      neg_quo_q <= 1'b0;
      neg_rem_q <= 1'b0;
      zero_q    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            rem_q     <= {{(W-1){1'b0}}, dvd_mag, 1'b0};
            spill_q   <= 1'b0;
            dvs_q     <= dvs_mag;
            neg_quo_q <= neg_quo_c;
            neg_rem_q <= neg_rem_c;
            zero_q    <= zero_c;
            iter      <= '0;
            busy      <= 1'b1;
            state     <= ST_RUN;
          end
        end
        ST_RUN: begin
          rem_q   <= step_rem;
          spill_q <= step_spill;
          iter    <= iter + CW'(1);
          if (iter == LAST) state <= ST_FIX;
        end
        ST_FIX: begin
          quotient  <= fix_quo;
          remainder <= fix_rem;
          done      <= 1'b1;
          busy      <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/restoring_divider_chk.sv
module restoring_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] dividend,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder
);
  int           lat_cnt;
  logic [W-1:0] cap_dvd;
  logic [W-1:0] cap_dvs;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cnt <= 0;
      cap_dvd <= '0;
      cap_dvs <= '1;
    end else if (start && !busy) begin
      lat_cnt <= 0;
      cap_dvd <= dividend;
      cap_dvs <= divisor;
    end else if (busy) begin
      lat_cnt <= lat_cnt + 1;
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == W + 1));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder)));

  // R6
  zero_div_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cap_dvs == '0) |-> (quotient == '1 && remainder == cap_dvd));
endmodule

bind restoring_divider restoring_divider_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .dividend  (dividend),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder)
);

// File: tb/restoring_divider_test.sv
module restoring_divider_test;
  localparam int W  = 32;
  localparam int NW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          start = 1'b0, signed_mode = 1'b0;
  logic [W-1:0]  dividend = '0, divisor = '0;
  logic          busy, done;
  logic [W-1:0]  quotient, remainder;

  logic          n_start = 1'b0, n_signed = 1'b0;
  logic [NW-1:0] n_dvd = '0, n_dvs = '0;
  logic          n_busy, n_done;
  logic [NW-1:0] n_quo, n_rem;

  int checks = 0;
  int errors = 0;

  restoring_divider #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  restoring_divider #(.W(NW)) uut_narrow (
    .clk(clk), .rst(rst), .start(n_start), .signed_mode(n_signed),
    .dividend(n_dvd), .divisor(n_dvs), .busy(n_busy), .done(n_done),
    .quotient(n_quo), .remainder(n_rem)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model(input longint a, input longint b, input int n, input bit sgn,
                                output longint q, output longint r);
    longint mask = (64'sd1 <<< n) - 1;
    longint sa = a;
    longint sb = b;
    if (b == 0) begin
      q = mask;
      r = a;
    end else begin
      if (sgn && a[n-1]) sa = a - (64'sd1 <<< n);
      if (sgn && b[n-1]) sb = b - (64'sd1 <<< n);
      q = (sa / sb) & mask;
      r = (sa % sb) & mask;
    end
  endfunction

  // called at a falling edge; launches immediately (back to back after done)
  task automatic run_wide(input logic [W-1:0] a, input logic [W-1:0] b, input bit s,
                          input string req, input bit poke);
    longint eq, er;
    logic [W-1:0] prev_q = quotient;
    logic [W-1:0] prev_r = remainder;
    int edges = 0;
    model(longint'(a), longint'(b), W, s, eq, er);
    start = 1'b1; signed_mode = s; dividend = a; divisor = b;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2 busy after accept", longint'(busy), 1);
    while (!done && edges < 200) begin
      @(negedge clk);
      edges++;
      if (poke && edges == 5) begin
        start = 1'b1; signed_mode = ~s; dividend = ~a; divisor = b + 1;
      end else begin
        start = 1'b0;
      end
      if (edges == 12)
        check(quotient == prev_q && remainder == prev_r, "R8 outputs held",
              longint'(quotient), longint'(prev_q));
    end
    check(edges == W + 1, "R3 latency", edges, W + 1);
    check(busy === 1'b0, "R3 busy low with done", longint'(busy), 0);
    check(quotient == W'(eq), {req, " quotient"}, longint'(quotient), eq);
    check(remainder == W'(er), {req, " remainder"}, longint'(remainder), er);
  endtask

  task automatic run_narrow(input logic [NW-1:0] a, input logic [NW-1:0] b, input bit s,
                            input string req);
    longint eq, er;
    int edges = 0;
    model(longint'(a), longint'(b), NW, s, eq, er);
    n_start = 1'b1; n_signed = s; n_dvd = a; n_dvs = b;
    @(negedge clk);
    n_start = 1'b0;
    while (!n_done && edges < 50) begin
      @(negedge clk);
      edges++;
    end
    check(edges == NW + 1, "R9 narrow latency", edges, NW + 1);
    check(n_quo == NW'(eq), {req, " narrow quotient"}, longint'(n_quo), eq);
    check(n_rem == NW'(er), {req, " narrow remainder"}, longint'(n_rem), er);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && quotient == 0 && remainder == 0, "R1 reset state",
          longint'(quotient), 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && done == 0 && quotient == 0 && remainder == 0, "R1 after release",
          longint'(remainder), 0);

    // R9 directed 7/2 on the narrow instance, then all 4-bit pairs in both modes
    run_narrow(4'd7, 4'd2, 1'b0, "R9 7/2");
    check(n_quo == 4'b0011 && n_rem == 4'b0001, "R9 fixed pattern", longint'(n_quo), 3);
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run_narrow(NW'(a), NW'(b), s[0], s[0] ? "R5 exhaustive" : "R4 exhaustive");

    @(negedge clk);
    run_wide(32'd7, 32'd2, 1'b0, "R4 7/2", 1'b0);
    run_wide(-32'sd7, 32'd2, 1'b1, "R5 -7/2", 1'b0);
    run_wide(32'd7, -32'sd2, 1'b1, "R5 7/-2", 1'b0);
    run_wide(-32'sd7, -32'sd2, 1'b1, "R5 -7/-2", 1'b0);
    run_wide(32'hFFFF_FFFF, 32'h8000_0001, 1'b0, "R4 top bits set", 1'b0);
    run_wide(32'hFFFF_FFFF, 32'd1, 1'b0, "R4 divide by one", 1'b0);
    run_wide(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R7 wrap", 1'b0);
    run_wide(32'h1234_5678, 32'd0, 1'b0, "R6 zero unsigned", 1'b0);
    run_wide(32'hFFFF_FFF9, 32'd0, 1'b1, "R6 zero signed", 1'b0);
    run_wide(32'd1000, 32'd33, 1'b0, "R2 start ignored while busy", 1'b1);
    run_wide(-32'sd1000, 32'd33, 1'b1, "R2 start ignored signed", 1'b1);

    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a = $urandom;
      logic [W-1:0] b = $urandom;
      bit s = i[0];
      if (i % 3 == 0) b = b >> ($urandom % 32);
      if (i % 17 == 0) b = '0;
      run_wide(a, b, s, s ? "R5 random" : "R4 random", (i % 23) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule